// File: doc/BRIEF.md
# Four-Channel Converter Host Register Interface

This block is the digital front end of a four-channel converter. Each channel has a coarse 10-bit main code and a fine 8-bit sub code. A host drives a 10-bit parallel bus and a two-bit channel address. A write strobe qualified by an active-low chip select commits each write. A mode pin routes the write to a control register or to a data input register. Control writes carry a selector bit that picks between one shared system configuration word and the addressed channel's configuration word.

Data can be loaded as full 10-bit words or as byte-wide pieces. In byte mode, one main code is built from two writes that may come in either order. Data lands in input registers first. An active-low load strobe copies every channel's input registers into the output registers in the same clock cycle. A hardware clear pin, a system clear bit and a per-channel clear bit force codes to a defined cleared value. That value depends on the selected number coding.

All host inputs are taken as synchronous to `clk`. A write commits on the clock edge at which a rising write strobe is seen, and the chip-select, mode, address and bus values at that edge are used.

Top module: `qdac_host_if`

## Requirements
- R1: After reset every main code is 0, every sub code is 0x80, and the power-down, system standby, per-channel standby and mux-select outputs are 0.
- R2: A write commits on the first clock edge where `wr_n` is high after being low the previous edge, provided `cs_n` is low at that edge. With `cs_n` high, a write changes no register.
- R3: With `mode` low, a write targets a control register. `db[0]`=0 selects the system word, in which `db[7]` selects byte mode, `db[6]` selects twos-complement coding, `db[5]` is power-down and `db[4]` is system standby. `db[0]`=1 selects the channel word of channel `addr`.
- R4: In a channel word, `db[9:8]` drives that channel's two mux-select outputs (`mux_sel[2n+1:2n]`), `db[7]`=1 routes later full-word data writes to the sub register, and `db[4]` drives `ch_stby[n]`.
- R5: In full-word mode (`db[7]` of the system word = 0), a data write (`mode` high) loads `db[9:0]` into the channel's main input register. If the channel's sub-route bit is set, it loads `db[7:0]` into the sub input register instead.
- R6: In byte mode, `db[0]`=1 loads `db[9:2]` into the sub input register. With `db[0]`=0, `db[1]`=0 loads `db[9:2]` into main bits 9..2 and `db[1]`=1 loads `db[3:2]` into main bits 1..0. The two halves may be written in either order.
- R7: `ldac_n` low at a clock edge copies all channels' input registers to the outputs (`main_code[10n+9:10n]`, `sub_code[8n+7:8n]`). A data write committing at the same edge reaches the output only on a later load.
- R8: `clr_n` low at a clock edge sets every input and output main register to 0 under binary coding, or to 0x200 under twos-complement coding, and every sub register to 0x80. The clear overrides data writes and loads at that edge. The coding used is the one in force after the edge.
- R9: A system-word write with `db[3]`=1 clears all channels, using the coding written by that same write. A channel-word write with `db[3]`=1 clears only the addressed channel. The clear bit itself is not stored.
- R10: `pwr_down` and `sys_stby` follow the power-down and standby bits last written to the system word. Writes to channel words do not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; its rising edge commits |
| mode | input | 1 | 0 = control write, 1 = data write |
| addr | input | 2 | Channel address |
| db | input | 10 | Parallel data/control bus |
| ldac_n | input | 1 | Load strobe, active low |
| clr_n | input | 1 | Hardware clear, active low |
| main_code | output | 40 | Main output codes, channel n at bits 10n+9..10n |
| sub_code | output | 32 | Sub output codes, channel n at bits 8n+7..8n |
| mux_sel | output | 8 | Per-channel mux selects, channel n at bits 2n+1..2n |
| ch_stby | output | 4 | Per-channel standby |
| pwr_down | output | 1 | System power-down |
| sys_stby | output | 1 | System standby |

## Verification
A data write, a load and a hardware clear can all fall on the same clock edge. The bench provokes this by lowering `ldac_n`, `clr_n` or both in the cycle where the write strobe rises. Both random and directed traffic do this. The expected outputs come from a bench model that applies three steps in order: the load copies the pre-write input values, then the write, then any clear. A load that outputs the freshly written word, or a write that survives a clear, therefore shows up as a mismatch.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH    = 4;
  localparam int MAIN_W = 10;
  localparam int SUB_W  = 8;

  typedef struct packed {
    logic word8;
    logic twos;
    logic pd;
    logic sstby;
  } sys_cfg_t;

  function automatic logic [MAIN_W-1:0] main_clear_val(input logic twos);
    logic [MAIN_W-1:0] v;
    v = '0;
    if (twos) v[MAIN_W-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [SUB_W-1:0] sub_clear_val();
    logic [SUB_W-1:0] v;
    v = '0;
    v[SUB_W-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/qdac_host_decode.sv
module qdac_host_decode #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              reg_sel,
  output logic              sys_we,
  output logic [NCH-1:0]    ctl_we,
  output logic [NCH-1:0]    data_we
);
  logic wr_q, wr_d;
  logic commit;

  always_comb wr_d = wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_d;
  end

  always_comb commit = ~cs_n & wr_n & ~wr_q;

  always_comb sys_we = commit & ~mode & ~reg_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    always_comb begin
      ctl_we[i]  = commit & ~mode & reg_sel & (addr == ADDR_W'(i));
      data_we[i] = commit &  mode &           (addr == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/qdac_ctrl_regs.sv
module qdac_ctrl_regs
  import qdac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sys_we,
  input  logic [NCH-1:0] ctl_we,
  input  logic [9:3]     fld,
  output sys_cfg_t       cfg,
  output logic [NCH-1:0] sub_route,
  output logic [2*NCH-1:0] mux_sel,
  output logic [NCH-1:0] ch_stby,
  output logic           clr_all,
  output logic [NCH-1:0] ch_clr,
  output logic           clr_twos
);
  sys_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d.word8 = fld[7];
    cfg_d.twos  = fld[6];
    cfg_d.pd    = fld[5];
    cfg_d.sstby = fld[4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (sys_we) cfg_q <= cfg_d;
  end

  always_comb begin
    cfg      = cfg_q;
    clr_all  = sys_we & fld[3];
    clr_twos = sys_we ? fld[6] : cfg_q.twos;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [3:0] word_q, word_d;

    always_comb word_d = {fld[9:8], fld[7], fld[4]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (ctl_we[i]) word_q <= word_d;
    end

    always_comb begin
      mux_sel[2*i+1:2*i] = word_q[3:2];
      sub_route[i]       = word_q[1];
      ch_stby[i]         = word_q[0];
      ch_clr[i]          = ctl_we[i] & fld[3];
    end
  end
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
  import qdac_pkg::*;
#(
  parameter int MW = MAIN_W,
  parameter int SW = SUB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [MW-1:0] db,
  input  logic          word8,
  input  logic          sub_route,
  input  logic          load,
  input  logic          clear,
  input  logic          clr_twos,
  output logic [MW-1:0] main_code,
  output logic [SW-1:0] sub_code
);
  logic [MW-1:0] main_in_q, main_in_d, main_out_q, main_out_d;
  logic [SW-1:0] sub_in_q,  sub_in_d,  sub_out_q,  sub_out_d;
  logic          en;

  always_comb begin
    main_in_d  = main_in_q;
    sub_in_d   = sub_in_q;
    main_out_d = main_out_q;
    sub_out_d  = sub_out_q;
    if (load) begin
      main_out_d = main_in_q;
      sub_out_d  = sub_in_q;
    end
    if (data_we) begin
      if (word8) begin
        if (db[0])      sub_in_d        = db[MW-1:2];
        else if (db[1]) main_in_d[1:0]  = db[3:2];
        else            main_in_d[MW-1:2] = db[MW-1:2];
      end else begin
        if (sub_route)  sub_in_d  = db[SW-1:0];
        else            main_in_d = db;
      end
    end
    if (clear) begin
      main_in_d  = main_clear_val(clr_twos);
      main_out_d = main_clear_val(clr_twos);
      sub_in_d   = sub_clear_val();
      sub_out_d  = sub_clear_val();
    end
    en = load | data_we | clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_in_q  <= '0;
      main_out_q <= '0;
      sub_in_q   <= sub_clear_val();
      sub_out_q  <= sub_clear_val();
    end else if (en) begin
      main_in_q  <= main_in_d;
      main_out_q <= main_out_d;
      sub_in_q   <= sub_in_d;
      sub_out_q  <= sub_out_d;
    end
  end

  always_comb begin
    main_code = main_out_q;
    sub_code  = sub_out_q;
  end
endmodule

// File: rtl/qdac_host_if.sv
module qdac_host_if
  import qdac_pkg::*;
#(
  parameter int NUM_CH = NCH,
  localparam int AW    = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   wr_n,
  input  logic                   mode,
  input  logic [AW-1:0]          addr,
  input  logic [MAIN_W-1:0]      db,
  input  logic                   ldac_n,
  input  logic                   clr_n,
  output logic [NUM_CH*MAIN_W-1:0] main_code,
  output logic [NUM_CH*SUB_W-1:0]  sub_code,
  output logic [2*NUM_CH-1:0]    mux_sel,
  output logic [NUM_CH-1:0]      ch_stby,
  output logic                   pwr_down,
  output logic                   sys_stby
);
  logic [1:0]        rst_sync;
  logic              irst_n;
  logic              sys_we;
  logic [NUM_CH-1:0] ctl_we, data_we, sub_route, ch_clr;
  logic              clr_all, clr_twos;
  sys_cfg_t          cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  always_comb irst_n = rst_sync[1];

  qdac_host_decode #(.NCH(NUM_CH), .ADDR_W(AW)) i_dec (
    .clk(clk), .rst_n(irst_n), .cs_n(cs_n), .wr_n(wr_n), .mode(mode),
    .addr(addr), .reg_sel(db[0]), .sys_we(sys_we), .ctl_we(ctl_we),
    .data_we(data_we)
  );

  qdac_ctrl_regs #(.NCH(NUM_CH)) i_ctrl (
    .clk(clk), .rst_n(irst_n), .sys_we(sys_we), .ctl_we(ctl_we),
    .fld(db[9:3]), .cfg(cfg), .sub_route(sub_route), .mux_sel(mux_sel),
    .ch_stby(ch_stby), .clr_all(clr_all), .ch_clr(ch_clr),
    .clr_twos(clr_twos)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic clear_i;
    always_comb clear_i = ~clr_n | clr_all | ch_clr[i];

    qdac_channel #(.MW(MAIN_W), .SW(SUB_W)) i_chan (
      .clk(clk), .rst_n(irst_n), .data_we(data_we[i]), .db(db),
      .word8(cfg.word8), .sub_route(sub_route[i]), .load(~ldac_n),
      .clear(clear_i), .clr_twos(clr_twos),
      .main_code(main_code[i*MAIN_W +: MAIN_W]),
      .sub_code(sub_code[i*SUB_W +: SUB_W])
    );
  end

  always_comb begin
    pwr_down = cfg.pd;
    sys_stby = cfg.sstby;
  end
endmodule

// File: rtl/qdac_host_if_chk.sv
module qdac_host_if_chk
  import qdac_pkg::*;
#(
  parameter int NUM_CH = NCH
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cs_n,
  input logic                     mode,
  input logic                     ldac_n,
  input logic                     clr_n,
  input logic [NUM_CH*MAIN_W-1:0] main_code,
  input logic [NUM_CH*SUB_W-1:0]  sub_code,
  input logic [2*NUM_CH-1:0]      mux_sel,
  input logic [NUM_CH-1:0]        ch_stby,
  input logic                     pwr_down,
  input logic                     sys_stby
);
  localparam logic [NUM_CH*SUB_W-1:0]  SUB_MID  = {NUM_CH{sub_clear_val()}};
  localparam logic [NUM_CH*MAIN_W-1:0] MAIN_MID = {NUM_CH{main_clear_val(1'b1)}};

  AST_IDLE_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && ldac_n && clr_n) |=> ($stable(main_code) && $stable(sub_code))); // R2

  AST_CTRL_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode || cs_n) |=> $stable({mux_sel, ch_stby, pwr_down, sys_stby})); // R3

  AST_HWCLR_SUB_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (sub_code == SUB_MID)); // R8

  AST_HWCLR_MAIN_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (main_code == '0 || main_code == MAIN_MID)); // R8
endmodule

bind qdac_host_if qdac_host_if_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode(mode), .ldac_n(ldac_n),
  .clr_n(clr_n), .main_code(main_code), .sub_code(sub_code),
  .mux_sel(mux_sel), .ch_stby(ch_stby), .pwr_down(pwr_down),
  .sys_stby(sys_stby)
);

// File: tb/test_qdac_host_if.sv
`timescale 1ns/1ps
module test_qdac_host_if;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, wr_n, mode, ldac_n, clr_n;
  logic [1:0]  addr;
  logic [9:0]  db;
  logic [39:0] main_code;
  logic [31:0] sub_code;
  logic [7:0]  mux_sel;
  logic [3:0]  ch_stby;
  logic        pwr_down, sys_stby;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [9:0] m_main_in [4], m_main_out [4];
  logic [7:0] m_sub_in [4], m_sub_out [4];
  logic [1:0] m_mux [4];
  logic       m_route [4], m_stby [4];
  logic       m_word8, m_twos, m_pd, m_sstby;

  always #4 clk = ~clk;

  qdac_host_if i_qdac_host_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .mode(mode),
    .addr(addr), .db(db), .ldac_n(ldac_n), .clr_n(clr_n),
    .main_code(main_code), .sub_code(sub_code), .mux_sel(mux_sel),
    .ch_stby(ch_stby), .pwr_down(pwr_down), .sys_stby(sys_stby)
  );

  function automatic logic [9:0] clr_main(input logic twos);
    return twos ? 10'h200 : 10'h000;
  endfunction

  task automatic m_clear_ch(input int c);
    m_main_in[c] = clr_main(m_twos); m_main_out[c] = clr_main(m_twos);
    m_sub_in[c] = 8'h80; m_sub_out[c] = 8'h80;
  endtask

  task automatic m_reset();
    m_word8 = 0; m_twos = 0; m_pd = 0; m_sstby = 0;
    for (int c = 0; c < 4; c++) begin
      m_mux[c] = 0; m_route[c] = 0; m_stby[c] = 0;
      m_clear_ch(c);
    end
  endtask

  task automatic m_write(input logic md, input logic [1:0] a, input logic [9:0] d);
    if (!md) begin
      if (!d[0]) begin
        m_word8 = d[7]; m_twos = d[6]; m_pd = d[5]; m_sstby = d[4];
        if (d[3]) for (int c = 0; c < 4; c++) m_clear_ch(c);
      end else begin
        m_mux[a] = d[9:8]; m_route[a] = d[7]; m_stby[a] = d[4];
        if (d[3]) m_clear_ch(a);
      end
    end else if (m_word8) begin
      if (d[0])      m_sub_in[a] = d[9:2];
      else if (d[1]) m_main_in[a][1:0] = d[3:2];
      else           m_main_in[a][9:2] = d[9:2];
    end else begin
      if (m_route[a]) m_sub_in[a] = d[7:0];
      else            m_main_in[a] = d;
    end
  endtask

  task automatic check_all(input string req);
    logic [39:0] em; logic [31:0] es; logic [7:0] ex; logic [3:0] et;
    for (int c = 0; c < 4; c++) begin
      em[c*10 +: 10] = m_main_out[c]; es[c*8 +: 8] = m_sub_out[c];
      ex[c*2 +: 2] = m_mux[c]; et[c] = m_stby[c];
    end
    checks++;
    if (main_code !== em || sub_code !== es || mux_sel !== ex ||
        ch_stby !== et || pwr_down !== m_pd || sys_stby !== m_sstby) begin
      failures++;
      $display("FAIL %s: main=%h/%h sub=%h/%h mux=%h/%h stby=%h/%h pd=%b/%b ss=%b/%b",
               req, main_code, em, sub_code, es, mux_sel, ex, ch_stby, et,
               pwr_down, m_pd, sys_stby, m_sstby);
    end
  endtask

  // write with optional same-edge load and hardware clear
  task automatic do_write(input logic csn, input logic md, input logic [1:0] a,
                          input logic [9:0] d, input logic ld, input logic hc);
    @(negedge clk);
    cs_n = csn; mode = md; addr = a; db = d; wr_n = 0;
    @(negedge clk);
    wr_n = 1; ldac_n = ~ld; clr_n = ~hc;
    @(negedge clk);
    cs_n = 1; ldac_n = 1; clr_n = 1;
    if (ld) for (int c = 0; c < 4; c++) begin
      m_main_out[c] = m_main_in[c]; m_sub_out[c] = m_sub_in[c];
    end
    if (!csn) m_write(md, a, d);
    if (hc) for (int c = 0; c < 4; c++) m_clear_ch(c);
  endtask

  task automatic do_load();
    do_write(1'b1, 1'b1, 2'd0, 10'h000, 1'b1, 1'b0);
  endtask

  initial begin
    rst_n = 0; cs_n = 1; wr_n = 1; mode = 0; addr = 0; db = 0;
    ldac_n = 1; clr_n = 1;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1 reset state");

    // R2: chip select high ignored
    do_write(1'b1, 1'b0, 2'd0, 10'h030, 1'b0, 1'b0);
    check_all("R2 cs high control write ignored");
    do_write(1'b1, 1'b1, 2'd1, 10'h155, 1'b1, 1'b0);
    check_all("R2 cs high data write ignored");

    // R3 / R10: system word, power-down and standby
    do_write(1'b0, 1'b0, 2'd0, 10'h030, 1'b0, 1'b0);
    check_all("R3 R10 system word pd+stby");
    // R4: channel word; R10 unchanged by it
    do_write(1'b0, 1'b0, 2'd2, 10'h311, 1'b0, 1'b0);
    check_all("R4 R10 channel word mux/stby");

    // R5: full-word main, then sub via route bit
    do_write(1'b0, 1'b1, 2'd1, 10'h2A7, 1'b0, 1'b0);
    check_all("R7 input held until load");
    do_load();
    check_all("R5 R7 full-word main loaded");
    do_write(1'b0, 1'b0, 2'd3, 10'h081, 1'b0, 1'b0);
    do_write(1'b0, 1'b1, 2'd3, 10'h35C, 1'b0, 1'b0);
    do_load();
    check_all("R5 full-word routed to sub");

    // R7: write and load on the same edge
    do_write(1'b0, 1'b1, 2'd0, 10'h1F0, 1'b1, 1'b0);
    check_all("R7 same-edge load sees old input");
    do_load();
    check_all("R7 next load shows new word");

    // R6: byte mode, low half first then high half
    do_write(1'b0, 1'b0, 2'd0, 10'h080, 1'b0, 1'b0);
    do_write(1'b0, 1'b1, 2'd2, 10'h00E, 1'b0, 1'b0);
    do_write(1'b0, 1'b1, 2'd2, 10'h2D4, 1'b0, 1'b0);
    do_write(1'b0, 1'b1, 2'd2, 10'h3C5, 1'b0, 1'b0);
    do_load();
    check_all("R6 byte mode low then high, sub byte");
    do_write(1'b0, 1'b1, 2'd1, 10'h150, 1'b0, 1'b0);
    do_write(1'b0, 1'b1, 2'd1, 10'h006, 1'b0, 1'b0);
    do_load();
    check_all("R6 byte mode high then low");

    // R8: hardware clear under twos coding, overriding a write and load
    do_write(1'b0, 1'b0, 2'd0, 10'h0C0, 1'b0, 1'b0);
    do_write(1'b0, 1'b1, 2'd3, 10'h3FD, 1'b1, 1'b1);
    check_all("R8 hw clear twos beats write+load");
    do_write(1'b0, 1'b1, 2'd0, 10'h3FC, 1'b0, 1'b0);
    do_write(1'b0, 1'b0, 2'd0, 10'h000, 1'b0, 1'b1);
    check_all("R8 hw clear uses coding after edge");

    // R9: channel clear then system clear with new coding
    do_write(1'b0, 1'b1, 2'd1, 10'h123, 1'b0, 1'b0);
    do_write(1'b0, 1'b1, 2'd2, 10'h321, 1'b1, 1'b0);
    do_write(1'b0, 1'b0, 2'd2, 10'h009, 1'b0, 1'b0);
    check_all("R9 channel clear only addressed");
    do_write(1'b0, 1'b0, 2'd0, 10'h048, 1'b0, 1'b0);
    check_all("R9 system clear with written coding");

    // random traffic
    begin
      int unsigned seed_v;
      seed_v = $urandom(32'h5EED_1234);
      for (int k = 0; k < 400; k++) begin
        logic csn_r, md_r, ld_r, hc_r;
        logic [1:0] a_r;
        logic [9:0] d_r;
        csn_r = ($urandom_range(0, 7) == 0);
        md_r  = ($urandom_range(0, 2) != 0);
        a_r   = 2'($urandom_range(0, 3));
        d_r   = 10'($urandom);
        if (!md_r && $urandom_range(0, 3) != 0) d_r[3] = 1'b0;
        ld_r  = ($urandom_range(0, 3) == 0);
        hc_r  = ($urandom_range(0, 31) == 0);
        do_write(csn_r, md_r, a_r, d_r, ld_r, hc_r);
        check_all("R2 R5 R6 R7 R8 random");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule